// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This controller chooses which hardware thread feeds a single-issue pipeline that several threads share. It holds one program counter per thread and keeps fetching from the active thread. Each thread's architectural register state lives outside the block, one copy per thread, so a switch never saves or restores it. The pipeline reports a long-latency stall, such as a second-level cache miss, together with the PC of the oldest instruction in flight, which is the missing load. The controller then records that PC as the thread's resume point and flushes the pipeline. Next it moves to another ready thread and drives that thread's PC to fetch. Instructions may not complete until a fixed refill window has passed.

A thread that stalled becomes ready again when its miss-return pulse arrives. The next thread is the ready thread with the highest 2-bit priority. Ties go round-robin, starting after the current thread. If no other thread is ready, the controller stays on the stalled thread and raises `idle` until a miss return arrives. Priorities and PCs can be loaded through a small write port.

Top module: `cg_thread_ctl`

## Requirements
- R1: Reset state. The active thread is 0 and each thread i has PC `RST_PC_BASE + i*RST_PC_STRIDE` (default 0 and 0x1000). All threads are ready and all priorities are 0. `idle` and `flush` are 0, and `commit_en` is 0 because a refill window starts at reset.
- R2: While not idle and not switching, `fetch_pc` shows the active thread's PC. In each cycle with `redir_vld`=1 that PC becomes `redir_pc`. Otherwise, in each cycle with `fetch_adv`=1, it advances by 4.
- R3: The active thread changes only after a cycle with `flush`=1, or when leaving idle. Apart from `stall_req`, no input switches threads.
- R4: An accepted stall asserts `flush` for exactly that cycle. It stores the stall PC as the thread's resume PC and marks the thread not ready. When that thread is chosen again, fetch restarts from the stored PC.
- R5: After a switch, `commit_en` stays 0 for exactly `REFILL` cycles (default 5) and then returns to 1.
- R6: The next thread is the ready thread with the highest priority. A higher value wins. Ties are broken in order act+1, act+2, and so on, modulo the thread count.
- R7: If no other thread is ready when a stall is accepted, `act_tid` is kept and `idle` rises. `idle` falls in the cycle after any miss return, with the thread chosen by R6 (the stalled thread included).
- R8: A `stall_req` that arrives during refill is held, together with its PC. It is accepted in the first cycle after the refill ends: `flush`=1 and `commit_en`=0 in that cycle.
- R9: With `cfg_we`=1, `cfg_sel`=0 writes `cfg_data[1:0]` to the priority of thread `cfg_tid`, and `cfg_sel`=1 writes `cfg_data` to its PC. A configuration write takes precedence over other updates to the same PC.
- R10: `stall_req` is ignored while `idle`=1: no flush occurs and no PC changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req | input | 1 | Long-latency stall reported by the active thread |
| stall_pc | input | 32 | PC of the oldest flushed instruction (resume PC) |
| miss_ret | input | 4 | Per-thread miss-return pulses |
| redir_vld | input | 1 | Branch or redirect for the active thread |
| redir_pc | input | 32 | Redirect target |
| fetch_adv | input | 1 | Fetch consumed the current PC |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0: priority, 1: PC |
| cfg_tid | input | 2 | Thread selected for the write |
| cfg_data | input | 32 | Write data |
| fetch_pc | output | 32 | PC driven to fetch |
| act_tid | output | 2 | Active thread |
| flush | output | 1 | Empty the pipeline this cycle |
| idle | output | 1 | No thread is ready to run |
| commit_en | output | 1 | Instructions may complete |

## Verification
A wrong ready bit or a wrong priority makes the next switch land on the wrong thread. This shows on `act_tid` and `fetch_pc` one cycle after `flush`. A corrupted resume PC stays hidden until that thread is chosen again, and then appears on `fetch_pc` in the very first cycle after the switch. An off-by-one refill counter, or a lost pending stall, moves the rising edge of `commit_en`, or the late `flush`, by a cycle. The bench therefore compares every output against its own model in every cycle.

// File: rtl/cg_thread_ctl.sv
`timescale 1ns/1ps
module cg_thread_ctl #(
  parameter int NTHR          = 4,
  parameter int PCW           = 32,
  parameter int PRIW          = 2,
  parameter int REFILL        = 5,
  parameter logic [31:0] RST_PC_BASE   = 32'h0,
  parameter logic [31:0] RST_PC_STRIDE = 32'h1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall_req,
  input  logic [PCW-1:0]          stall_pc,
  input  logic [NTHR-1:0]         miss_ret,
  input  logic                    redir_vld,
  input  logic [PCW-1:0]          redir_pc,
  input  logic                    fetch_adv,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [$clog2(NTHR)-1:0] cfg_tid,
  input  logic [PCW-1:0]          cfg_data,
  output logic [PCW-1:0]          fetch_pc,
  output logic [$clog2(NTHR)-1:0] act_tid,
  output logic                    flush,
  output logic                    idle,
  output logic                    commit_en
);
  localparam int TW = $clog2(NTHR);
  localparam int CW = $clog2(REFILL + 1);

  logic [PCW-1:0]  pc_q  [NTHR];
  logic [PRIW-1:0] pri_q [NTHR];
  logic [NTHR-1:0] ready_q, ready_n, act_oh;
  logic [TW-1:0]   act_q, nxt;
  logic [CW-1:0]   cnt_q;
  logic            idle_q, pend_q, found, take;
  logic [PCW-1:0]  pend_pc_q, take_pc;

  assign act_oh    = NTHR'(1) << act_q;
  assign take      = (cnt_q == '0) && !idle_q && (pend_q || stall_req);
  assign take_pc   = pend_q ? pend_pc_q : stall_pc;
  assign ready_n   = (ready_q | miss_ret) & ~(take ? act_oh : '0);
  assign fetch_pc  = pc_q[act_q];
  assign act_tid   = act_q;
  assign flush     = take;
  assign idle      = idle_q;
  assign commit_en = (cnt_q == '0) && !idle_q && !pend_q;

  always_comb begin
    found = 1'b0;
    nxt   = act_q;
    for (int k = 1; k <= NTHR; k++) begin
      logic [TW-1:0] idx;
      idx = act_q + TW'(k);
      if (ready_n[idx] && (!found || pri_q[idx] > pri_q[nxt])) begin
        found = 1'b1;
        nxt   = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) begin
        pc_q[i]  <= PCW'(RST_PC_BASE + RST_PC_STRIDE * i);
        pri_q[i] <= '0;
      end
      ready_q   <= '1;
      act_q     <= '0;
      cnt_q     <= CW'(REFILL);
      idle_q    <= 1'b0;
      pend_q    <= 1'b0;
      pend_pc_q <= '0;
    end else begin
      ready_q <= ready_n;
      if (take) begin
        pc_q[act_q] <= take_pc;
        pend_q      <= 1'b0;
        if (found) begin
          act_q <= nxt;
          cnt_q <= CW'(REFILL);
        end else begin
          idle_q <= 1'b1;
        end
      end else if (idle_q) begin
        if (found) begin
          act_q  <= nxt;
          idle_q <= 1'b0;
          cnt_q  <= CW'(REFILL);
        end
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (stall_req && cnt_q != '0 && !pend_q) begin
          pend_q    <= 1'b1;
          pend_pc_q <= stall_pc;
        end
        if (redir_vld)      pc_q[act_q] <= redir_pc;
        else if (fetch_adv) pc_q[act_q] <= pc_q[act_q] + PCW'(4);
      end
      if (cfg_we) begin
        if (cfg_sel) pc_q[cfg_tid]  <= cfg_data;
        else         pri_q[cfg_tid] <= cfg_data[PRIW-1:0];
      end
    end
  end

  p_stable_thread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !flush) |=> $stable(act_tid));
  p_single_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  p_refill_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !commit_en);
  p_active_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_q |-> ready_q[act_q]);
  p_idle_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && miss_ret == '0) |=> (idle && $stable(act_tid)));
  p_idle_no_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !flush);
endmodule

// File: tb/cg_thread_ctl_tb_top.sv
`timescale 1ns/1ps
module cg_thread_ctl_tb_top;
  localparam int REF = 5;
  logic clk = 0, rst_n = 0;
  logic stall_req = 0, redir_vld = 0, fetch_adv = 0, cfg_we = 0, cfg_sel = 0;
  logic [31:0] stall_pc = 0, redir_pc = 0, cfg_data = 0;
  logic [3:0] miss_ret = 0;
  logic [1:0] cfg_tid = 0;
  logic [31:0] fetch_pc;
  logic [1:0] act_tid;
  logic flush, idle, commit_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cg_thread_ctl dut_i (.clk, .rst_n, .stall_req, .stall_pc, .miss_ret, .redir_vld,
    .redir_pc, .fetch_adv, .cfg_we, .cfg_sel, .cfg_tid, .cfg_data,
    .fetch_pc, .act_tid, .flush, .idle, .commit_en);

  logic [31:0] m_pc [4];
  logic [1:0]  m_pri [4];
  logic [3:0]  m_rdy;
  int m_act, m_cnt;
  bit m_idle, m_pend;
  logic [31:0] m_ppc;

  task automatic chk(bit ok, string req, string what, longint a, longint e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  function automatic int pick(logic [3:0] m);
    int best = -1;
    for (int k = 1; k <= 4; k++) begin
      int idx = (m_act + k) % 4;
      if (m[idx] && (best < 0 || m_pri[idx] > m_pri[best])) best = idx;
    end
    return best;
  endfunction

  function automatic bit m_take();
    return m_cnt == 0 && !m_idle && (m_pend || stall_req);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_pc[i] = 32'h1000 * i; m_pri[i] = 0; end
    m_rdy = 4'hF; m_act = 0; m_cnt = REF; m_idle = 0; m_pend = 0; m_ppc = 0;
  endtask

  task automatic model_tick();
    bit t = m_take();
    logic [3:0] rn = m_rdy | miss_ret;
    int n;
    if (t) rn[m_act] = 1'b0;
    n = pick(rn);
    if (t) begin
      m_pc[m_act] = m_pend ? m_ppc : stall_pc;
      m_pend = 0;
      if (n >= 0) begin m_act = n; m_cnt = REF; end else m_idle = 1;
    end else if (m_idle) begin
      if (n >= 0) begin m_act = n; m_idle = 0; m_cnt = REF; end
    end else begin
      if (stall_req && m_cnt != 0 && !m_pend) begin m_pend = 1; m_ppc = stall_pc; end
      if (m_cnt != 0) m_cnt--;
      if (redir_vld) m_pc[m_act] = redir_pc;
      else if (fetch_adv) m_pc[m_act] = m_pc[m_act] + 4;
    end
    if (cfg_we) begin
      if (cfg_sel) m_pc[cfg_tid] = cfg_data; else m_pri[cfg_tid] = cfg_data[1:0];
    end
    m_rdy = rn;
  endtask

  task automatic cyc();
    #0.5;
    chk(fetch_pc == m_pc[m_act], "R2", "fetch_pc", fetch_pc, m_pc[m_act]);
    chk(act_tid == m_act[1:0], "R6", "act_tid", act_tid, m_act);
    chk(flush == m_take(), "R4", "flush", flush, m_take());
    chk(idle == m_idle, "R7", "idle", idle, m_idle);
    chk(commit_en == (m_cnt == 0 && !m_idle && !m_pend), "R5", "commit_en", commit_en,
        (m_cnt == 0 && !m_idle && !m_pend));
    @(posedge clk);
    model_tick();
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1; model_reset();
    #0.1;
    chk(act_tid == 0 && fetch_pc == 0, "R1", "reset thread/pc", {act_tid, fetch_pc}, 0);
    chk(!idle && !flush && !commit_en, "R1", "reset flags", {idle, flush, commit_en}, 0);
    repeat (REF) cyc();
    chk(commit_en == 1, "R5", "commit after refill", commit_en, 1);
    stall_req = 1; stall_pc = 32'h40; #0.1;
    chk(flush == 1, "R4", "flush on stall", flush, 1);
    cyc(); stall_req = 0;
    chk(act_tid == 1 && fetch_pc == 32'h1000, "R6", "round-robin tie", act_tid, 1);
    cyc();
    stall_req = 1; stall_pc = 32'h1080; #0.1;
    chk(flush == 0, "R8", "no flush during refill", flush, 0);
    cyc(); stall_req = 0;
    repeat (3) cyc();
    #0.1;
    chk(flush == 1 && commit_en == 0, "R8", "held stall taken", {flush, commit_en}, 2'b10);
    cyc();
    chk(act_tid == 2, "R8", "switch after held stall", act_tid, 2);
    repeat (REF) cyc();
    stall_req = 1; stall_pc = 32'h2000; cyc(); stall_req = 0;
    chk(act_tid == 3, "R6", "next ready thread", act_tid, 3);
    repeat (REF) cyc();
    stall_req = 1; stall_pc = 32'h3000; cyc();
    chk(idle == 1 && act_tid == 3, "R7", "idle holds thread", {idle, act_tid}, 3'b111);
    #0.1;
    chk(flush == 0, "R10", "stall ignored in idle", flush, 0);
    cyc(); stall_req = 0;
    chk(fetch_pc == 32'h3000, "R10", "pc untouched in idle", fetch_pc, 32'h3000);
    miss_ret = 4'b0010; cyc(); miss_ret = 0;
    chk(idle == 0 && act_tid == 1, "R7", "leave idle on return", {idle, act_tid}, 3'b001);
    chk(fetch_pc == 32'h1080, "R4", "resume pc", fetch_pc, 32'h1080);
    miss_ret = 4'b1101; cfg_we = 1; cfg_sel = 0; cfg_tid = 3; cfg_data = 1; cyc();
    miss_ret = 0; cfg_we = 0;
    repeat (REF) cyc();
    stall_req = 1; stall_pc = 32'h1100; cyc(); stall_req = 0;
    chk(act_tid == 3, "R9", "priority beats round-robin", act_tid, 3);
    fetch_adv = 1; cyc();
    chk(fetch_pc == 32'h3004, "R2", "advance by 4", fetch_pc, 32'h3004);
    redir_vld = 1; redir_pc = 32'h700; cyc(); redir_vld = 0; fetch_adv = 0;
    chk(fetch_pc == 32'h700, "R2", "redirect wins", fetch_pc, 32'h700);
    cfg_we = 1; cfg_sel = 1; cfg_tid = 3; cfg_data = 32'h900; cyc(); cfg_we = 0;
    chk(fetch_pc == 32'h900, "R9", "pc write", fetch_pc, 32'h900);
    for (int c = 0; c < 4000; c++) begin
      stall_req = ($urandom % 8) == 0;
      stall_pc  = $urandom & 32'hFFFF_FFFC;
      miss_ret  = 4'($urandom) & 4'($urandom) & 4'($urandom) & ~m_rdy;
      redir_vld = ($urandom % 10) == 0;
      redir_pc  = $urandom & 32'hFFFF_FFFC;
      fetch_adv = $urandom % 2;
      cfg_we    = ($urandom % 40) == 0;
      cfg_sel   = $urandom % 2;
      cfg_tid   = 2'($urandom);
      cfg_data  = $urandom & 32'hFFFF_FFFC;
      cyc();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule